// File: doc/BRIEF.md
# Double-Buffered Endpoint DMA Request Generator

This block raises transfer requests toward a dual-address DMA controller for two endpoints whose data sits in double-buffered FIFOs. One endpoint carries data from the host (receive), the other carries data to the host (transmit). Each FIFO half reports whether it is full and whether it is empty. The block folds these flags into one request line per endpoint.

The two directions follow opposite rules. The receive request comes up as soon as any half holds a full packet. It stays up until every half has been drained. The transmit request comes up as soon as any half is empty. It stays up until every half has been filled. Between those two points the request keeps its last value, so a half that has been read or written only in part neither raises nor drops it.

A CPU-writable control word holds one enable bit per endpoint. Enabling DMA does not mask the FIFO full or empty interrupts. Software must therefore keep those interrupt enables cleared while DMA runs.

Top module: `epdma_req`

## Requirements
- R1: During and right after reset, both enable bits are 0, `cfg_rdata` is 0 and both request outputs are 0.
- R2: A write with `cfg_wr`=1 stores `cfg_wdata[0]` as the receive enable and `cfg_wdata[1]` as the transmit enable at that clock edge. `cfg_rdata[1:0]` returns the stored enables. All higher bits of `cfg_rdata` read 0 whatever was written to them.
- R3: With the receive enable set, if any receive half has its full flag at 1 at a clock edge, `rx_dreq` is 1 after that edge.
- R4: With the receive enable set, if no receive half is full and every receive half is empty at a clock edge, `rx_dreq` is 0 after that edge.
- R5: With the receive enable set, if no receive half is full and at least one is not empty, `rx_dreq` keeps its previous value.
- R6: With the transmit enable set, if any transmit half has its empty flag at 1 at a clock edge, `tx_dreq` is 1 after that edge.
- R7: With the transmit enable set, if no transmit half is empty and every transmit half is full at a clock edge, `tx_dreq` is 0 after that edge.
- R8: With the transmit enable set, if no transmit half is empty and at least one is not full, `tx_dreq` keeps its previous value.
- R9: While an endpoint's stored enable is 0, its request output is 0. Clearing an enable drops the request at the same edge that stores the write. A request first becomes eligible one edge after its enable is stored as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the enable word |
| cfg_wdata | input | REG_W | Write data; bit 0 receive enable, bit 1 transmit enable |
| cfg_rdata | output | REG_W | Read-back of the enable word, upper bits 0 |
| rx_full | input | HALVES | Per-half full flag of the receive FIFO |
| rx_empty | input | HALVES | Per-half empty flag of the receive FIFO |
| tx_full | input | HALVES | Per-half full flag of the transmit FIFO |
| tx_empty | input | HALVES | Per-half empty flag of the transmit FIFO |
| rx_dreq | output | 1 | DMA request for the receive endpoint |
| tx_dreq | output | 1 | DMA request for the transmit endpoint |

## Verification
The hardest case to reach is the hold region. There, one half is partly filled and the other is not at its trigger level, so the request must keep whatever value an earlier edge left. The random stimulus picks each half's state among full, empty and partial, and never marks a half both full and empty. It also lets states persist over several cycles, so it passes through the hold region from both a raised and a dropped request. Directed sequences first walk each endpoint through raise, hold-high, drop and hold-low, and then through disabling while a request is up.

// File: rtl/epdma_pkg.sv
package epdma_pkg;

   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } ep_dir_e;

   localparam int unsigned EN_BITS = 2;
   localparam int unsigned EN_RX   = 0;
   localparam int unsigned EN_TX   = 1;

endpackage

// File: rtl/epdma_cfg_reg.sv
module epdma_cfg_reg #(
   parameter int unsigned REG_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [REG_W-1:0]             wdata,
   output logic [REG_W-1:0]             rdata,
   output logic [epdma_pkg::EN_BITS-1:0] en
);
   localparam int unsigned NEN = epdma_pkg::EN_BITS;
   localparam int unsigned PAD = REG_W - NEN;

   if (REG_W < NEN) begin : g_bad_width
      $error("epdma_cfg_reg: REG_W must hold the enable bits");
   end

   logic [NEN-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr) begin
         en_q <= wdata[NEN-1:0];
      end
   end

   assign en = en_q;

   if (PAD > 0) begin : g_pad
      assign rdata = {{PAD{1'b0}}, en_q};
   end else begin : g_nopad
      assign rdata = en_q;
   end

   // R2: a write shows up in the read-back after the edge
   p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (rdata[NEN-1:0] == $past(wdata[NEN-1:0])));
   // R2: without a write the read-back does not move
   p_no_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(rdata));

endmodule

// File: rtl/epdma_ep_req.sv
module epdma_ep_req
   import epdma_pkg::*;
#(
   parameter ep_dir_e     DIR    = DIR_RX,
   parameter int unsigned HALVES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HALVES-1:0] full,
   input  logic [HALVES-1:0] empty,
   output logic              dreq
);
   if (HALVES < 1) begin : g_bad_halves
      $error("epdma_ep_req: HALVES must be at least 1");
   end

   logic set_c;
   logic clr_c;
   logic req_q;

   if (DIR == DIR_RX) begin : g_rx
      // data waiting: raise on any full half, drop when drained
      assign set_c = |full;
      assign clr_c = &empty;
   end else begin : g_tx
      // room available: raise on any empty half, drop when filled
      assign set_c = |empty;
      assign clr_c = &full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (!en) begin
         req_q <= 1'b0;
      end else if (set_c) begin
         req_q <= 1'b1;
      end else if (clr_c) begin
         req_q <= 1'b0;
      end
   end

   assign dreq = req_q & en;

   if (DIR == DIR_RX) begin : g_rx_chk
      p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (en && (|full)) |=> req_q);
      p_rx_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !(|full) && (&empty)) |=> !req_q);
      p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !(|full) && !(&empty)) |=> (req_q == $past(req_q)));
   end else begin : g_tx_chk
      p_tx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (en && (|empty)) |=> req_q);
      p_tx_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !(|empty) && (&full)) |=> !req_q);
      p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !(|empty) && !(&full)) |=> (req_q == $past(req_q)));
   end

endmodule

// File: rtl/epdma_req.sv
module epdma_req
   import epdma_pkg::*;
#(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned HALVES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic [HALVES-1:0] rx_full,
   input  logic [HALVES-1:0] rx_empty,
   input  logic [HALVES-1:0] tx_full,
   input  logic [HALVES-1:0] tx_empty,
   output logic              rx_dreq,
   output logic              tx_dreq
);
   logic [EN_BITS-1:0] en;

   epdma_cfg_reg #(.REG_W(REG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .en    (en)
   );

   epdma_ep_req #(.DIR(DIR_RX), .HALVES(HALVES)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en[EN_RX]),
      .full  (rx_full),
      .empty (rx_empty),
      .dreq  (rx_dreq)
   );

   epdma_ep_req #(.DIR(DIR_TX), .HALVES(HALVES)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en[EN_TX]),
      .full  (tx_full),
      .empty (tx_empty),
      .dreq  (tx_dreq)
   );

   // R9: a disabled endpoint never requests
   p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en[EN_RX] |-> !rx_dreq);
   p_tx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en[EN_TX] |-> !tx_dreq);
   // R1: reset clears both requests
   p_rst_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!rx_dreq && !tx_dreq && (cfg_rdata == '0)));

endmodule

// File: tb/epdma_req_bench.sv
module epdma_req_bench;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned HALVES = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [REG_W-1:0]  cfg_wdata = '0;
   logic [REG_W-1:0]  cfg_rdata;
   logic [HALVES-1:0] rx_full = '0, rx_empty = '1, tx_full = '0, tx_empty = '1;
   logic              rx_dreq, tx_dreq;

   int n_chk = 0;
   int n_bad = 0;
   logic [1:0] m_en = 2'b00;
   logic       m_rxq = 1'b0, m_txq = 1'b0;

   always #10 clk = ~clk;

   epdma_req #(.REG_W(REG_W), .HALVES(HALVES)) u_epdma_req (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .rx_full(rx_full), .rx_empty(rx_empty),
      .tx_full(tx_full), .tx_empty(tx_empty), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
   );

   function automatic logic next_req(input logic en_old, input logic set_c,
                                     input logic clr_c, input logic cur);
      if (!en_old) return 1'b0;
      if (set_c) return 1'b1;
      if (clr_c) return 1'b0;
      return cur;
   endfunction

   function automatic string rx_tag(input logic en, input logic [HALVES-1:0] f,
                                    input logic [HALVES-1:0] e);
      if (!en) return "R9";
      if (|f) return "R3";
      if (&e) return "R4";
      return "R5";
   endfunction

   function automatic string tx_tag(input logic en, input logic [HALVES-1:0] f,
                                    input logic [HALVES-1:0] e);
      if (!en) return "R9";
      if (|e) return "R6";
      if (&f) return "R7";
      return "R8";
   endfunction

   task automatic check(input string tag, input logic [REG_W-1:0] act,
                        input logic [REG_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // half state: 0 full, 1 empty, 2 partial
   task automatic set_half(input int sel, input int st, input int h);
      logic f, e;
      f = (st == 0);
      e = (st == 1);
      case (sel)
         0: begin rx_full[h] = f; rx_empty[h] = e; end
         default: begin tx_full[h] = f; tx_empty[h] = e; end
      endcase
   endtask

   task automatic step(input logic wr, input logic [REG_W-1:0] wd);
      logic [1:0] en_old;
      string rt, tt;
      cfg_wr = wr;
      cfg_wdata = wd;
      @(posedge clk);
      en_old = m_en;
      if (wr) m_en = wd[1:0];
      m_rxq = next_req(en_old[0], |rx_full, &rx_empty, m_rxq);
      m_txq = next_req(en_old[1], |tx_empty, &tx_full, m_txq);
      rt = rx_tag(en_old[0] & m_en[0], rx_full, rx_empty);
      tt = tx_tag(en_old[1] & m_en[1], tx_full, tx_empty);
      @(negedge clk);
      cfg_wr = 1'b0;
      check(rt, {31'd0, rx_dreq}, {31'd0, m_rxq & m_en[0]});
      check(tt, {31'd0, tx_dreq}, {31'd0, m_txq & m_en[1]});
      check("R2", cfg_rdata, {30'd0, m_en});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int seed;
      seed = $urandom(32'd20417);
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      check("R1", {30'd0, rx_dreq, tx_dreq}, '0);
      check("R1", cfg_rdata, '0);
      rst_n = 1'b1;
      // R1: still quiet right after reset, halves in triggering states
      rx_full = 2'b01; rx_empty = 2'b10; tx_full = 2'b00; tx_empty = 2'b11;
      step(1'b0, '0);
      check("R1", {30'd0, rx_dreq, tx_dreq}, '0);
      // R2: upper bits read zero
      step(1'b1, 32'hFFFF_FFFF);
      check("R2", cfg_rdata, 32'h3);
      // R3 / R6: requests rise one edge later
      step(1'b0, '0);
      check("R3", {31'd0, rx_dreq}, 32'd1);
      check("R6", {31'd0, tx_dreq}, 32'd1);
      // R5 / R8: partial halves hold high
      rx_full = 2'b00; rx_empty = 2'b01;
      tx_full = 2'b01; tx_empty = 2'b00;
      step(1'b0, '0);
      check("R5", {31'd0, rx_dreq}, 32'd1);
      check("R8", {31'd0, tx_dreq}, 32'd1);
      // R4 / R7: drained / filled drop
      rx_empty = 2'b11; tx_full = 2'b11;
      step(1'b0, '0);
      check("R4", {31'd0, rx_dreq}, 32'd0);
      check("R7", {31'd0, tx_dreq}, 32'd0);
      // R5 / R8: partial halves hold low
      rx_empty = 2'b10; tx_full = 2'b10;
      step(1'b0, '0);
      check("R5", {31'd0, rx_dreq}, 32'd0);
      check("R8", {31'd0, tx_dreq}, 32'd0);
      // R9: raise, then disable receive only
      rx_full = 2'b10; rx_empty = 2'b00; tx_full = 2'b00; tx_empty = 2'b01;
      step(1'b0, '0);
      step(1'b1, 32'h2);
      check("R9", {31'd0, rx_dreq}, 32'd0);
      check("R6", {31'd0, tx_dreq}, 32'd1);
      step(1'b1, 32'h0);
      check("R9", {31'd0, tx_dreq}, 32'd0);
      // constrained random
      for (int i = 0; i < 600; i++) begin
         if ($urandom % 4 == 0) begin
            for (int h = 0; h < HALVES; h++) set_half(0, int'($urandom % 3), h);
         end
         if ($urandom % 4 == 0) begin
            for (int h = 0; h < HALVES; h++) set_half(1, int'($urandom % 3), h);
         end
         if ($urandom % 16 == 0) step(1'b1, $urandom);
         else step(1'b0, '0);
      end
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule